// File: doc/BRIEF.md
# Handshaked Byte Command Receiver

This block takes command messages from a host one byte at a time over an 8-bit bus. Each byte moves under a four-phase request/acknowledge handshake. The host raises `host_syn` with a byte on `host_data`. The receiver answers with `host_ack` and keeps it high until the host drops its request. The receiver only pays attention to bytes that fall inside a frame. A frame opens with the marker 0x55 and closes with the marker 0xAA. The receiver works out the frame length from the opcode, which is the byte right after the opening marker. Because of this, marker values that appear inside address or data fields do not end a message early.

When a whole frame has arrived, the receiver raises a one-cycle pulse to the downstream parser. At the same time it presents the stored bytes (the opening marker at index 0) and the byte count. It then refuses to acknowledge any further byte until the parser confirms that it has taken the command. Frames that break the length rule, or that would overrun the buffer, are discarded without a pulse.

Top module: `cmd_frame_rx`

## Requirements
- R1: When `host_syn` is high and `host_ack` is low, and no command is pending, `host_ack` rises one cycle later. It stays high while `host_syn` stays high and falls in the cycle after `host_syn` drops.
- R2: Outside a frame, every byte other than 0x55 is acknowledged and then discarded. It produces no command pulse and is not stored.
- R3: The opcodes 0x01, 0x10 and 0x11 imply total frame lengths of 3, 5 and 9 bytes, counting both markers. When 0xAA arrives in the last position, the command completes and `cmd_len` equals that length.
- R4: For a known opcode, a 0xAA or 0x55 byte at any position before the implied last one is stored as payload and does not end the frame.
- R5: For a known opcode, a byte other than 0xAA in the implied last position drops the frame. The receiver goes back to hunting for 0x55.
- R6: For any other opcode, the first 0xAA after the opcode ends the frame, and `cmd_len` counts every byte from 0x55 through that 0xAA.
- R7: For an unknown opcode, if the DEPTH-th byte of the frame is not 0xAA, the frame is dropped without a pulse and the receiver goes back to hunting. A 0xAA that arrives exactly as the DEPTH-th byte still completes a command of length DEPTH.
- R8: `cmd_valid` is high for exactly one cycle per completed frame. Byte i of the frame (0x55 at i = 0) appears on `cmd_bytes[8*i+7:8*i]`. `cmd_bytes` and `cmd_len` hold steady until `cmd_taken`.
- R9: While a command is pending, `host_ack` stays low whatever `host_syn` does. A `cmd_taken` in cycle t releases the receiver, and a waiting byte is acknowledged no earlier than cycle t+2.
- R10: After reset, `host_ack` and `cmd_valid` are low and the receiver is hunting for 0x55.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_syn | input | 1 | Host request: a byte is present on `host_data` |
| host_data | input | 8 | Byte from the host |
| host_ack | output | 1 | Receiver acknowledge of the current byte |
| cmd_taken | input | 1 | Parser confirms that it has consumed the pending command |
| cmd_valid | output | 1 | One-cycle pulse: a complete command is in the buffer |
| cmd_bytes | output | 8*DEPTH | Buffered frame bytes, index 0 in the low byte |
| cmd_len | output | $clog2(DEPTH+1) | Number of valid bytes in `cmd_bytes` |

## Verification
The two functions that can land in one cycle are the parser's release (`cmd_taken`) and a new byte request from the host. The bench holds `host_syn` high with the next opening marker while a command is pending, and checks over several cycles that no acknowledge appears and that the held bytes and length stay unchanged. It then schedules `cmd_taken` in a cycle where the request is still high. The bench requires `host_ack` to stay low in that cycle and the next, then rise one cycle later. The frame started by that byte must then complete with the correct contents.

// File: rtl/cmd_rx_pkg.sv
package cmd_rx_pkg;

    localparam logic [7:0] MARK_OPEN  = 8'h55;
    localparam logic [7:0] MARK_CLOSE = 8'hAA;

    localparam logic [7:0] OPC_RESET = 8'h01;
    localparam logic [7:0] OPC_READ  = 8'h10;
    localparam logic [7:0] OPC_WRITE = 8'h11;

    typedef enum logic [1:0] {
        FS_HUNT,
        FS_BODY,
        FS_HOLD
    } frm_state_e;

    // Total frame length implied by an opcode; zero means "unknown".
    function automatic logic [7:0] implied_len(input logic [7:0] opc);
        case (opc)
            OPC_RESET: implied_len = 8'd3;
            OPC_READ:  implied_len = 8'd5;
            OPC_WRITE: implied_len = 8'd9;
            default:   implied_len = 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/rxhs_handshake.sv
module rxhs_handshake (
    input  logic clk,
    input  logic rst_n,
    input  logic syn_i,
    input  logic blocked_i,
    output logic ack_o,
    output logic accept_o
);

    typedef struct packed {
        logic ack;
    } hs_t;

    hs_t hs_d, hs_q;
    logic take_byte;

    always_comb begin
        hs_d      = hs_q;
        take_byte = syn_i && !hs_q.ack && !blocked_i;
        if (take_byte) begin
            hs_d.ack = 1'b1;
        end else if (hs_q.ack && !syn_i) begin
            hs_d.ack = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= '0;
        end else begin
            hs_q <= hs_d;
        end
    end

    assign ack_o    = hs_q.ack;
    assign accept_o = take_byte;

    // R1: acknowledge stays up while the request is held
    a_r1_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        hs_q.ack && syn_i |=> hs_q.ack);

    // R1: acknowledge falls the cycle after the request drops
    a_r1_ack_falls: assert property (@(posedge clk) disable iff (!rst_n)
        hs_q.ack && !syn_i |=> !hs_q.ack);

    // R9: no new acknowledge while the framer blocks intake
    a_r9_no_ack_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        blocked_i && !hs_q.ack |=> !hs_q.ack);

endmodule

// File: rtl/rxfr_framer.sv
module rxfr_framer
    import cmd_rx_pkg::*;
#(
    parameter int DEPTH = 12,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic [7:0]       data_i,
    input  logic             taken_i,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic             hold_o,
    output logic             valid_o,
    output logic [LEN_W-1:0] len_o
);

    typedef struct packed {
        frm_state_e       st;
        logic [IDX_W-1:0] cnt;
        logic [LEN_W-1:0] want;
        logic             valid;
        logic [LEN_W-1:0] len;
    } fr_t;

    fr_t fr_d, fr_q;
    logic             known;
    logic             at_last;
    logic             at_limit;
    logic [LEN_W-1:0] cnt_ext;

    always_comb begin
        fr_d     = fr_q;
        fr_d.valid = 1'b0;
        wr_en_o  = 1'b0;
        wr_idx_o = fr_q.cnt;
        cnt_ext  = LEN_W'(fr_q.cnt);
        known    = (fr_q.want != '0);
        at_last  = (cnt_ext == fr_q.want - LEN_W'(1));
        at_limit = (fr_q.cnt == IDX_W'(DEPTH - 1));

        case (fr_q.st)
            FS_HUNT: begin
                if (accept_i && data_i == MARK_OPEN) begin
                    wr_en_o  = 1'b1;
                    wr_idx_o = '0;
                    fr_d.cnt = IDX_W'(1);
                    fr_d.st  = FS_BODY;
                end
            end
            FS_BODY: begin
                if (accept_i) begin
                    wr_en_o = 1'b1;
                    if (fr_q.cnt == IDX_W'(1)) begin
                        fr_d.want = LEN_W'(implied_len(data_i));
                        fr_d.cnt  = IDX_W'(2);
                    end else if (known) begin
                        if (at_last) begin
                            if (data_i == MARK_CLOSE) begin
                                fr_d.st    = FS_HOLD;
                                fr_d.valid = 1'b1;
                                fr_d.len   = cnt_ext + LEN_W'(1);
                            end else begin
                                fr_d.st = FS_HUNT;
                            end
                        end else begin
                            fr_d.cnt = fr_q.cnt + IDX_W'(1);
                        end
                    end else begin
                        if (data_i == MARK_CLOSE) begin
                            fr_d.st    = FS_HOLD;
                            fr_d.valid = 1'b1;
                            fr_d.len   = cnt_ext + LEN_W'(1);
                        end else if (at_limit) begin
                            fr_d.st = FS_HUNT;
                        end else begin
                            fr_d.cnt = fr_q.cnt + IDX_W'(1);
                        end
                    end
                end
            end
            FS_HOLD: begin
                if (taken_i) begin
                    fr_d.st = FS_HUNT;
                end
            end
            default: fr_d.st = FS_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q    <= '0;
            fr_q.st <= FS_HUNT;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign hold_o  = (fr_q.st == FS_HOLD);
    assign valid_o = fr_q.valid;
    assign len_o   = fr_q.len;

    // R8: completion strobe lasts a single cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.valid |=> !fr_q.valid);

    // R9: a pending command stays pending until the parser takes it
    a_r9_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.st == FS_HOLD && !taken_i |=> fr_q.st == FS_HOLD);

    // R7: a reported length never exceeds the buffer and covers both markers
    a_r7_len_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.valid |-> (fr_q.len >= LEN_W'(3)) && (fr_q.len <= LEN_W'(DEPTH)));

endmodule

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
    parameter int DEPTH = 12,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [7:0]         wr_data_i,
    output logic [8*DEPTH-1:0] bytes_o
);

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en_i) begin
            mem_d[wr_idx_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign bytes_o[8*g +: 8] = mem_q[g];
    end

endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx #(
    parameter int DEPTH = 12,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_syn,
    input  logic [7:0]         host_data,
    output logic               host_ack,
    input  logic               cmd_taken,
    output logic               cmd_valid,
    output logic [8*DEPTH-1:0] cmd_bytes,
    output logic [LEN_W-1:0]   cmd_len
);

    logic             accept;
    logic             hold;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;

    rxhs_handshake u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .syn_i     (host_syn),
        .blocked_i (hold),
        .ack_o     (host_ack),
        .accept_o  (accept)
    );

    rxfr_framer #(.DEPTH(DEPTH)) u_fr (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .data_i   (host_data),
        .taken_i  (cmd_taken),
        .wr_en_o  (wr_en),
        .wr_idx_o (wr_idx),
        .hold_o   (hold),
        .valid_o  (cmd_valid),
        .len_o    (cmd_len)
    );

    rxbuf_store #(.DEPTH(DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (host_data),
        .bytes_o   (cmd_bytes)
    );

    // R8: buffered bytes stay put while the command waits for the parser
    a_r8_bytes_stable: assert property (@(posedge clk) disable iff (!rst_n)
        hold && !cmd_taken |=> $stable(cmd_bytes) && $stable(cmd_len));

endmodule

// File: tb/tb_cmd_frame_rx.sv
module tb_cmd_frame_rx;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 12;
    localparam int LEN_W      = $clog2(DEPTH + 1);
    localparam int LIMIT      = 20000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               host_syn = 1'b0;
    logic [7:0]         host_data = '0;
    logic               host_ack;
    logic               cmd_taken = 1'b0;
    logic               cmd_valid;
    logic [8*DEPTH-1:0] cmd_bytes;
    logic [LEN_W-1:0]   cmd_len;

    typedef struct packed {
        logic [7:0]         len;
        logic [8*DEPTH-1:0] bytes;
    } exp_t;

    exp_t       expq[$];
    logic [7:0] txq[$];
    int  n_vec = 0;
    int  n_bad = 0;
    int  cyc = 0;
    int  take_cyc = -1;
    bit  auto_take = 1'b1;

    cmd_frame_rx #(.DEPTH(DEPTH)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_syn  (host_syn),
        .host_data (host_data),
        .host_ack  (host_ack),
        .cmd_taken (cmd_taken),
        .cmd_valid (cmd_valid),
        .cmd_bytes (cmd_bytes),
        .cmd_len   (cmd_len)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each completion pulse and drives the parser release
    always @(negedge clk) begin
        cmd_taken = (auto_take && cmd_valid) || (cyc == take_cyc);
        if (rst_n && cmd_valid) begin
            chk(expq.size() > 0, "R8 pulse with nothing expected", 128'(cmd_len), 128'(0));
            if (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                chk(8'(cmd_len) == e.len, "R3/R6 cmd_len", 128'(cmd_len), 128'(e.len));
                for (int i = 0; i < int'(e.len); i++) begin
                    chk(cmd_bytes[8*i +: 8] == e.bytes[8*i +: 8], "R8 buffered byte",
                        128'(cmd_bytes[8*i +: 8]), 128'(e.bytes[8*i +: 8]));
                end
            end
        end
    end

    always @(posedge clk) begin
        if (cyc >= LIMIT) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Driver: one four-phase byte transfer; entered just after a falling edge
    task automatic send_byte(input logic [7:0] b);
        host_data = b;
        host_syn  = 1'b1;
        @(negedge clk);
        chk(host_ack == 1'b1, "R1 ack rise", 128'(host_ack), 128'(1));
        host_syn = 1'b0;
        @(negedge clk);
        chk(host_ack == 1'b0, "R1 ack fall", 128'(host_ack), 128'(0));
    endtask

    task automatic push_exp(input int first, input int n);
        exp_t e;
        e = '0;
        e.len = 8'(n);
        for (int i = 0; i < n; i++) begin
            e.bytes[8*i +: 8] = txq[first + i];
        end
        expq.push_back(e);
    endtask

    task automatic send_all();
        foreach (txq[i]) send_byte(txq[i]);
        txq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(host_ack == 1'b0 && cmd_valid == 1'b0, "R10 reset state",
            128'({host_ack, cmd_valid}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R2 + R3: noise outside a frame, then a reset command
        txq = '{8'h00, 8'hAA, 8'h12, 8'h55, 8'h01, 8'hAA};
        push_exp(3, 3);
        send_all();

        // R3: read command
        txq = '{8'h55, 8'h10, 8'h12, 8'h34, 8'hAA};
        push_exp(0, 5);
        send_all();

        // R4: write command whose payload is full of marker values
        txq = '{8'h55, 8'h11, 8'hAA, 8'h55, 8'hAA, 8'hAA, 8'h55, 8'h55, 8'hAA};
        push_exp(0, 9);
        send_all();

        // R4: read command with close markers in the address
        txq = '{8'h55, 8'h10, 8'hAA, 8'hAA, 8'hAA};
        push_exp(0, 5);
        send_all();

        // R5: wrong byte at the end position drops the frame; the next frame survives
        txq = '{8'h55, 8'h10, 8'h00, 8'h01, 8'h77, 8'hAA, 8'h55, 8'h01, 8'hAA};
        push_exp(6, 3);
        send_all();

        // R6: unknown opcode ends at first close marker
        txq = '{8'h55, 8'h33, 8'h44, 8'hAA};
        push_exp(0, 4);
        send_all();

        // R6/R7 boundary: close marker exactly as the DEPTH-th byte
        txq = '{8'h55, 8'h40, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06,
                8'h07, 8'h08, 8'h09, 8'hAA};
        push_exp(0, 12);
        send_all();

        // R7: no close marker within DEPTH bytes drops the frame
        txq = '{8'h55, 8'h40, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06,
                8'h07, 8'h08, 8'h09, 8'h0A, 8'hAA, 8'h55, 8'h10, 8'h00, 8'h08, 8'hAA};
        push_exp(13, 5);
        send_all();

        // R9: stall while pending, then release coinciding with a held request
        auto_take = 1'b0;
        txq = '{8'h55, 8'h01, 8'hAA};
        push_exp(0, 3);
        send_all();
        host_data = 8'h55;
        host_syn  = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(host_ack == 1'b0, "R9 stalled while pending", 128'(host_ack), 128'(0));
        end
        chk(cmd_bytes[23:0] == 24'hAA0155 && cmd_len == LEN_W'(3) && !cmd_valid,
            "R8 held contents", 128'({cmd_valid, cmd_len, cmd_bytes[23:0]}),
            128'({1'b0, LEN_W'(3), 24'hAA0155}));
        take_cyc = cyc + 1;
        @(negedge clk);
        chk(host_ack == 1'b0, "R9 no ack in release cycle", 128'(host_ack), 128'(0));
        @(negedge clk);
        chk(host_ack == 1'b0, "R9 no ack one cycle after release", 128'(host_ack), 128'(0));
        @(negedge clk);
        chk(host_ack == 1'b1, "R9 ack two cycles after release", 128'(host_ack), 128'(1));
        host_syn = 1'b0;
        @(negedge clk);
        chk(host_ack == 1'b0, "R1 ack fall after release", 128'(host_ack), 128'(0));
        auto_take = 1'b1;
        txq = '{8'h55, 8'h10, 8'hBE, 8'hEF, 8'hAA};
        push_exp(0, 5);
        void'(txq.pop_front());
        send_all();

        repeat (5) @(negedge clk);
        chk(expq.size() == 0, "R2/R5/R7 outstanding commands", 128'(expq.size()), 128'(0));

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule